// File: doc/BRIEF.md
# Exception Vector Address Generator

This block sits beside the fetch unit of a processor whose exception table holds one instruction per exception, each in a fixed 4-byte slot. When one or more exception requests arrive, it picks the single winner by fixed priority. It then forms the fetch target by ORing that exception's slot offset into the active table base. It presents the result as a registered one-cycle redirect.

The table base is either low memory (0x00000000) or high memory (0xFFFF0000). A strap input chooses the base while reset is held. Once reset is released, a control bit that software writes chooses it; that bit starts from the sampled strap. Leaving reset always produces a reset redirect in the first clock cycle. Mode switching, register banking, return-address saving and the fetch itself belong to other blocks.

Request bits use these positions and exception codes: bit 0 reset (code 0, offset 0x00), bit 1 undefined instruction (code 1, offset 0x04), bit 2 supervisor call (code 2, offset 0x08), bit 3 prefetch abort (code 3, offset 0x0C), bit 4 data abort (code 4, offset 0x10), bit 5 reserved (code 5), bit 6 IRQ (code 6, offset 0x18), bit 7 FIQ (code 7, offset 0x1C). The code equals the offset divided by 4.

Top module: `exvec_gen`

## Requirements
- R1: While rst_n is low, redir_vld_o is 0.
- R2: On the first rising clock edge with rst_n high, the block outputs redir_vld_o=1, code 0 and the active base. Any requests sampled at that same edge are discarded.
- R3: hivec_strap_i is sampled only on clock edges while rst_n is low. Changing it after reset does not move the base.
- R4: hivec_wr_i=1 loads hivec_wdata_i into the base-select bit, where 1 selects 0xFFFF0000 and 0 selects 0x00000000. A request sampled at the same edge as the write still uses the base that was in effect before that edge.
- R5: Each exception's target offset is 4 times its code: 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 and 0x1C.
- R6: When several requests are set together, the winner follows this order, highest first: reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, supervisor call.
- R7: Request bit 5 is ignored. Code 5 and offset 0x14 are never produced.
- R8: redir_vld_o is 1 in the cycle after each edge that samples at least one valid request, and 0 after an edge that samples none.
- R9: A reset request (bit 0) overrides every other request.
- R10: redir_addr_o equals the active base ORed with the winning offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; async clear of the outputs |
| exc_req_i | input | 8 | Exception request bits, positions as listed above |
| hivec_strap_i | input | 1 | Base select strap, sampled during reset |
| hivec_wr_i | input | 1 | Write strobe for the base-select bit |
| hivec_wdata_i | input | 1 | Value written to the base-select bit |
| redir_vld_o | output | 1 | One-cycle redirect strobe |
| redir_code_o | output | 3 | Winning exception code |
| redir_addr_o | output | 32 | Redirect fetch address |

## Verification
Every result is due one clock edge after the edge that samples its stimulus. A request or reset release is driven on a falling edge, passes through the output registers on the next rising edge, and is compared on the following falling edge. A base-select write takes effect at the same edge that samples it, so it changes only the redirect triggered by the next request. The bench therefore compares against the base that was in effect before the write. The boot redirect is compared on the falling edge right after the first rising edge with reset released, and a quiet output is checked on the falling edge after that.

// File: rtl/exvec_pkg.sv
package exvec_pkg;

   localparam int EXC_N  = 8;
   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      EXC_RESET  = 3'd0,
      EXC_UNDEF  = 3'd1,
      EXC_SVCALL = 3'd2,
      EXC_PFABT  = 3'd3,
      EXC_DABT   = 3'd4,
      EXC_RSVD   = 3'd5,
      EXC_IRQ    = 3'd6,
      EXC_FIQ    = 3'd7
   } exc_code_e;

   localparam int PRIO_N = 7;

   // Highest priority first (R6)
   localparam exc_code_e PRIO_ORDER [PRIO_N] = '{
      EXC_RESET, EXC_DABT, EXC_FIQ, EXC_IRQ, EXC_PFABT, EXC_UNDEF, EXC_SVCALL
   };

   localparam logic [EXC_N-1:0] REQ_VALID_MASK = ~(EXC_N'(1) << EXC_RSVD);

endpackage

// File: rtl/exvec_arbiter.sv
module exvec_arbiter
   import exvec_pkg::*;
(
   input  logic [EXC_N-1:0]  req_i,
   output logic              any_o,
   output exc_code_e         win_o
);

   logic [EXC_N-1:0] req_m;

   // Reserved slot is dropped before arbitration (R7)
   assign req_m = req_i & REQ_VALID_MASK;
   assign any_o = |req_m;

   // Lowest priority is visited first, so higher ones overwrite (R6, R9)
   always_comb begin
      win_o = EXC_RESET;
      for (int i = PRIO_N - 1; i >= 0; i--) begin
         if (req_m[PRIO_ORDER[i]]) begin
            win_o = PRIO_ORDER[i];
         end
      end
   end

endmodule

// File: rtl/exvec_offset.sv
module exvec_offset
   import exvec_pkg::*;
#(
   parameter int SLOT_BYTES = 4,
   localparam int OFS_W     = $clog2(SLOT_BYTES * EXC_N)
)(
   input  exc_code_e         code_i,
   output logic [OFS_W-1:0]  ofs_o
);

   localparam int SLOT_SH = $clog2(SLOT_BYTES);

   generate
      if ((1 << SLOT_SH) == SLOT_BYTES) begin : g_shift
         assign ofs_o = OFS_W'(code_i) << SLOT_SH;
      end else begin : g_mult
         assign ofs_o = OFS_W'(OFS_W'(code_i) * OFS_W'(SLOT_BYTES));
      end
   endgenerate

endmodule

// File: rtl/exvec_base_ctl.sv
module exvec_base_ctl #(
   parameter bit HIVEC_SW_EN = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic strap_i,
   input  logic wr_i,
   input  logic wdata_i,
   output logic hi_o
);

   logic hi_q;

   generate
      if (HIVEC_SW_EN) begin : g_sw
         // Strap tracked while in reset, software owns it afterwards (R3, R4)
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hi_q <= strap_i;
            end else if (wr_i) begin
               hi_q <= wdata_i;
            end
         end
      end else begin : g_strap_only
         logic unused_wr;
         assign unused_wr = wr_i ^ wdata_i;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hi_q <= strap_i;
            end
         end
      end
   endgenerate

   assign hi_o = hi_q;

endmodule

// File: rtl/exvec_gen.sv
module exvec_gen
   import exvec_pkg::*;
#(
   parameter int                  ADDR_W      = 32,
   parameter logic [ADDR_W-1:0]   LOW_BASE    = 32'h0000_0000,
   parameter logic [ADDR_W-1:0]   HIGH_BASE   = 32'hFFFF_0000,
   parameter int                  SLOT_BYTES  = 4,
   parameter bit                  HIVEC_SW_EN = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [EXC_N-1:0]    exc_req_i,
   input  logic                hivec_strap_i,
   input  logic                hivec_wr_i,
   input  logic                hivec_wdata_i,
   output logic                redir_vld_o,
   output logic [CODE_W-1:0]   redir_code_o,
   output logic [ADDR_W-1:0]   redir_addr_o
);

   localparam int OFS_W = $clog2(SLOT_BYTES * EXC_N);
   localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << OFS_W) - 1);

   // Elaboration-time parameter checks
   if (ADDR_W < OFS_W || ADDR_W > 64) begin : g_bad_addr_w
      $error("exvec_gen: ADDR_W out of range");
   end
   if (SLOT_BYTES < 1) begin : g_bad_slot
      $error("exvec_gen: SLOT_BYTES must be positive");
   end
   if (((LOW_BASE | HIGH_BASE) & OFS_MASK) != '0) begin : g_bad_base
      $error("exvec_gen: base overlaps the offset field");
   end

   logic               base_hi;
   logic               req_any;
   exc_code_e          req_win;
   exc_code_e          sel_code;
   logic [OFS_W-1:0]   sel_ofs;
   logic [ADDR_W-1:0]  sel_base;
   logic               boot_pend_q;

   exvec_base_ctl #(
      .HIVEC_SW_EN (HIVEC_SW_EN)
   ) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (hivec_strap_i),
      .wr_i    (hivec_wr_i),
      .wdata_i (hivec_wdata_i),
      .hi_o    (base_hi)
   );

   exvec_arbiter u_arb (
      .req_i (exc_req_i),
      .any_o (req_any),
      .win_o (req_win)
   );

   // Pending boot entry beats any request (R2)
   assign sel_code = boot_pend_q ? EXC_RESET : req_win;

   exvec_offset #(
      .SLOT_BYTES (SLOT_BYTES)
   ) u_ofs (
      .code_i (sel_code),
      .ofs_o  (sel_ofs)
   );

   assign sel_base = base_hi ? HIGH_BASE : LOW_BASE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_pend_q  <= 1'b1;
         redir_vld_o  <= 1'b0;
         redir_code_o <= '0;
         redir_addr_o <= '0;
      end else begin
         boot_pend_q  <= 1'b0;
         redir_vld_o  <= boot_pend_q | req_any;
         redir_code_o <= sel_code;
         redir_addr_o <= sel_base | ADDR_W'(sel_ofs);
      end
   end

endmodule

// File: rtl/exvec_gen_chk.sv
module exvec_gen_chk
   import exvec_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] LOW_BASE    = 32'h0000_0000,
   parameter logic [ADDR_W-1:0] HIGH_BASE   = 32'hFFFF_0000,
   parameter int                SLOT_BYTES  = 4,
   parameter bit                HIVEC_SW_EN = 1'b1
)(
   input logic                clk,
   input logic                rst_n,
   input logic [EXC_N-1:0]    exc_req_i,
   input logic                hivec_wr_i,
   input logic                hivec_wdata_i,
   input logic                base_hi,
   input logic                redir_vld_o,
   input logic [CODE_W-1:0]   redir_code_o,
   input logic [ADDR_W-1:0]   redir_addr_o
);

   localparam int OFS_W = $clog2(SLOT_BYTES * EXC_N);
   localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << OFS_W) - 1);

   logic run1_q, run2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run1_q <= 1'b0;
         run2_q <= 1'b0;
      end else begin
         run1_q <= 1'b1;
         run2_q <= run1_q;
      end
   end

   // R1
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         a_r1_quiet_in_reset: assert (redir_vld_o == 1'b0);
      end
   end

   a_r2_boot_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (run1_q && !run2_q) |-> (redir_vld_o && redir_code_o == EXC_RESET &&
         (redir_addr_o == LOW_BASE || redir_addr_o == HIGH_BASE)));

   a_r3_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run1_q && !$past(hivec_wr_i)) |-> $stable(base_hi));

   if (HIVEC_SW_EN) begin : g_wr_chk
      a_r4_wr_loads: assert property (@(posedge clk) disable iff (!rst_n)
         (run1_q && $past(hivec_wr_i)) |-> (base_hi == $past(hivec_wdata_i)));
   end

   a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld_o |-> (redir_code_o != EXC_RSVD));

   a_r6_dabt_rank: assert property (@(posedge clk) disable iff (!rst_n)
      (run2_q && $past(exc_req_i[EXC_DABT])) |->
         (redir_code_o == EXC_RESET || redir_code_o == EXC_DABT));

   a_r9_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (run2_q && $past(exc_req_i[EXC_RESET])) |->
         (redir_vld_o && redir_code_o == EXC_RESET));

   a_r8_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (run2_q && redir_vld_o) |-> $past(|(exc_req_i & REQ_VALID_MASK)));

   a_r10_addr_form: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld_o |->
         ((redir_addr_o & OFS_MASK) == ADDR_W'(redir_code_o) * ADDR_W'(SLOT_BYTES) &&
          ((redir_addr_o & ~OFS_MASK) == LOW_BASE ||
           (redir_addr_o & ~OFS_MASK) == HIGH_BASE)));

endmodule

bind exvec_gen exvec_gen_chk #(
   .ADDR_W      (ADDR_W),
   .LOW_BASE    (LOW_BASE),
   .HIGH_BASE   (HIGH_BASE),
   .SLOT_BYTES  (SLOT_BYTES),
   .HIVEC_SW_EN (HIVEC_SW_EN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .exc_req_i     (exc_req_i),
   .hivec_wr_i    (hivec_wr_i),
   .hivec_wdata_i (hivec_wdata_i),
   .base_hi       (base_hi),
   .redir_vld_o   (redir_vld_o),
   .redir_code_o  (redir_code_o),
   .redir_addr_o  (redir_addr_o)
);

// File: tb/exvec_gen_bench.sv
`timescale 1ns/1ps
module exvec_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req = '0;
   logic        strap = 1'b0;
   logic        wr = 1'b0;
   logic        wdata = 1'b0;
   logic        vld;
   logic [2:0]  code;
   logic [31:0] addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   exvec_gen u_exvec_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .exc_req_i     (req),
      .hivec_strap_i (strap),
      .hivec_wr_i    (wr),
      .hivec_wdata_i (wdata),
      .redir_vld_o   (vld),
      .redir_code_o  (code),
      .redir_addr_o  (addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] base_of(input bit hi);
      return hi ? 32'hFFFF_0000 : 32'h0000_0000;
   endfunction

   // Priority: reset, dabt, fiq, irq, pfabt, undef, svc
   function automatic int winner(input logic [7:0] r);
      if (r[0]) return 0;
      if (r[4]) return 4;
      if (r[7]) return 7;
      if (r[6]) return 6;
      if (r[3]) return 3;
      if (r[1]) return 1;
      if (r[2]) return 2;
      return -1;
   endfunction

   // Drive at a falling edge, result checked one falling edge later
   task automatic fire(input logic [7:0] r, input bit hi, input string tag);
      int w;
      @(negedge clk);
      req = r;
      @(negedge clk);
      req = '0;
      w = winner(r);
      if (w < 0) begin
         chk({tag, " R8 R7 idle"}, 32'(vld), 32'd0);
      end else begin
         chk({tag, " R8 vld"}, 32'(vld), 32'd1);
         chk({tag, " R6 R9 code"}, 32'(code), 32'(w));
         chk({tag, " R5 R10 addr"}, addr, base_of(hi) | 32'(w * 4));
      end
   endtask

   task automatic do_reset(input bit s);
      @(negedge clk);
      rst_n = 1'b0;
      strap = s;
      repeat (3) @(negedge clk);
      chk("R1 vld in reset", 32'(vld), 32'd0);
      rst_n = 1'b1;
      req = 8'hFF;
      @(negedge clk);
      req = '0;
      chk("R2 boot vld", 32'(vld), 32'd1);
      chk("R2 boot code", 32'(code), 32'd0);
      chk("R2 boot addr", addr, base_of(s));
      @(negedge clk);
      chk("R2 boot-cycle requests dropped", 32'(vld), 32'd0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset(1'b1);

      // R3: strap change after reset has no effect
      strap = 1'b0;
      fire(8'h40, 1'b1, "R3 strap ignored");

      // R4: write with a same-edge request keeps the old base
      @(negedge clk);
      wr = 1'b1; wdata = 1'b0; req = 8'h80;
      @(negedge clk);
      wr = 1'b0; req = '0;
      chk("R4 same-edge addr", addr, 32'hFFFF_001C);
      fire(8'h80, 1'b0, "R4 new base");

      // Sweep every request pattern under both bases
      for (int b = 0; b < 2; b++) begin
         @(negedge clk);
         wr = 1'b1; wdata = b[0];
         @(negedge clk);
         wr = 1'b0;
         for (int r = 0; r < 256; r++) begin
            fire(8'(r), b[0], "sweep");
         end
      end

      // R8: held request gives a redirect on every cycle
      @(negedge clk);
      req = 8'h08;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R8 held req vld", 32'(vld), 32'd1);
         chk("R5 held req addr", addr, 32'hFFFF_000C);
      end
      req = '0;

      // R7: reserved bit alone gives nothing
      fire(8'h20, 1'b1, "R7 reserved only");

      do_reset(1'b0);
      fire(8'h10, 1'b0, "R2 low boot base");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule